// File: doc/BRIEF.md
# VEX Prefix Stream Decoder

This block sits at the front of an instruction decode path and takes instruction bytes one at a time. It skips any legacy prefix bytes, spots the start of a VEX prefix in either its compact two-byte form or its full three-byte form, and turns the packed prefix payload into one uniform set of decoded fields. These fields are the register-extension bits, the operand-width bit, the extra source register index, the vector length, the implied legacy prefix and the opcode map. Fields that are stored in one's complement are inverted on the way out. The fields that the compact form leaves out are filled with fixed defaults.

After the prefix, the block captures the opcode byte. For VEX instructions it also captures the ModR/M byte, splits it into its three fields, and reports whether a SIB byte follows. It flags a VEX prefix that comes after a disallowed legacy prefix, and it flags opcode maps outside the supported set. When no VEX lead byte appears, the first byte that is not a prefix is passed through as the opcode.

Input follows valid/ready rules: a byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low while a finished record waits at the output. One record comes out per instruction through `out_valid`/`out_ready`. The record holds steady until the cycle in which `out_ready` is seen high, and that handshake is the per-instruction done pulse. The decoder is then ready for the next instruction's first byte on the following cycle.

Top module: `vex_stream_decoder`

## Requirements
- R1: A byte is consumed only on an edge with `in_valid` and `in_ready` high. While `out_valid` is high, `in_ready` is low, and any offered byte is ignored. The record stays unchanged until the edge where `out_ready` is high, after which `out_valid` drops and `in_ready` rises.
- R2: A synchronous reset, even in the middle of an instruction, leaves `out_valid` low and `in_ready` high, and clears all partial state.
- R3: Without a lead byte, bytes F0, 66, F2, F3, 40..4F, 67, 26, 2E, 36, 3E, 64 and 65 are skipped as prefixes. The first other byte is reported as `o_opcode` with `o_vex`=0, `o_modrm_present`=0, `o_illegal`=0, and all VEX fields, map, indices and SIB flag zero.
- R4: Lead byte C4 starts the three-byte form (`o_vex3`=1). Its first payload byte is, MSB first, inverted R, inverted X, inverted B, map[4:0]. Its second payload byte is W, inverted v[3:0], L, pp[1:0]. R, X, B and the source index are output un-inverted.
- R5: Lead byte C5 starts the two-byte form (`o_vex3`=0). Its payload byte is inverted R, inverted v[3:0], L, pp[1:0]. W=0, X=0, B=0 and map=1 are supplied as defaults.
- R6: `o_pp` repeats pp, and `o_pfx_byte` gives the implied prefix: pp 0 gives 00, 1 gives 66, 2 gives F3, and 3 gives F2.
- R7: `o_vl256` equals L (0 means 128-bit, 1 means 256-bit).
- R8: `o_map_bad` is high for a VEX instruction whose map is not 1, 2 or 3.
- R9: `o_illegal` is high for a VEX instruction if any byte before the lead byte was F0, 66, F2, F3 or 40..4F. Bytes 67 and segment overrides (26, 2E, 36, 3E, 64, 65) are allowed.
- R10: A VEX opcode is followed by a ModR/M byte unless the map is 1 and the opcode is 77. That byte is split into `o_mod` (bits 7:6), `o_reg` (5:3) and `o_rm` (2:0). `o_reg_idx`={R,reg} and `o_rm_idx`={B,rm}. All five are zero when no ModR/M byte is present.
- R11: `o_sib_follows` is high exactly when a ModR/M byte is present, rm is 100 and mod is not 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder can take a byte |
| out_valid | output | 1 | Decoded record available |
| out_ready | input | 1 | Consumer takes the record |
| o_vex | output | 1 | Instruction carried a VEX prefix |
| o_vex3 | output | 1 | Prefix was the three-byte form |
| o_illegal | output | 1 | Disallowed prefix before VEX |
| o_map_bad | output | 1 | Unsupported opcode map |
| o_rext | output | 1 | Register field extension (R) |
| o_xext | output | 1 | Index extension (X) |
| o_bext | output | 1 | Base/rm extension (B) |
| o_wide | output | 1 | Operand-width bit (W) |
| o_vsrc | output | 4 | Extra source register index |
| o_vl256 | output | 1 | Vector length, 1 for 256-bit |
| o_pp | output | 2 | Implied prefix code |
| o_pfx_byte | output | 8 | Implied prefix byte value |
| o_map | output | 5 | Opcode map |
| o_opcode | output | 8 | Opcode byte |
| o_modrm_present | output | 1 | ModR/M byte was captured |
| o_mod | output | 2 | ModR/M mod field |
| o_reg | output | 3 | ModR/M reg field |
| o_rm | output | 3 | ModR/M rm field |
| o_reg_idx | output | 4 | Extended reg index |
| o_rm_idx | output | 4 | Extended rm index |
| o_sib_follows | output | 1 | A SIB byte comes next |

## Verification
Every one of the 256 values is swept through each payload position: the three-byte first payload byte, which covers all map values and the inversion of R, X and B; the three-byte second payload byte; the two-byte payload; and the ModR/M byte. These sweeps show that each bit lands in its own field with the correct polarity, and they separate the map, pp and SIB boundaries. Every byte value is also sent as the first byte of a plain instruction and as a single prefix before a two-byte VEX, which tells skipped prefixes from opcodes and allowed prefixes from forbidden ones. Directed cases cover opcode 77 in map 1 against map 2, output back-pressure with bytes offered during the hold, and a reset in the middle of a prefix.

// File: rtl/vex_dec_pkg.sv
package vex_dec_pkg;
  localparam int BYTE_W = 8;
  localparam int MAP_W  = 5;
  localparam int IDX_W  = 4;
  localparam logic [BYTE_W-1:0] LEAD3_BYTE = 8'hC4;
  localparam logic [BYTE_W-1:0] LEAD2_BYTE = 8'hC5;
  localparam logic [BYTE_W-1:0] NO_MRM_OPC = 8'h77;
  localparam logic [MAP_W-1:0]  MAP_ESC0F  = 5'd1;
  localparam logic [MAP_W-1:0]  MAP_LAST   = 5'd3;

  typedef enum logic [2:0] {
    ST_PFX, ST_V3A, ST_V3B, ST_V2A, ST_OPC, ST_MRM, ST_OUT
  } dec_state_t;

  typedef enum logic [2:0] {
    BC_PFX_OK, BC_PFX_BAD, BC_LEAD3, BC_LEAD2, BC_OTHER
  } byte_cls_t;

  typedef struct packed {
    logic              rext;
    logic              xext;
    logic              bext;
    logic              wide;
    logic [IDX_W-1:0]  vsrc;
    logic              vl256;
    logic [1:0]        pp;
    logic [BYTE_W-1:0] pfx_byte;
    logic [MAP_W-1:0]  map;
    logic              map_bad;
  } vex_fields_t;
endpackage

// File: rtl/vex_byte_class.sv
module vex_byte_class
  import vex_dec_pkg::*;
(
  input  logic [BYTE_W-1:0] byte_in,
  output byte_cls_t         cls
);
  logic is_seg, is_asz, is_rex, is_bad;

  always_comb begin
    is_seg = (byte_in == 8'h26) || (byte_in == 8'h2E) || (byte_in == 8'h36) ||
             (byte_in == 8'h3E) || (byte_in == 8'h64) || (byte_in == 8'h65);
    is_asz = (byte_in == 8'h67);
    is_rex = (byte_in[7:4] == 4'h4);
    is_bad = is_rex || (byte_in == 8'hF0) || (byte_in == 8'h66) ||
             (byte_in == 8'hF2) || (byte_in == 8'hF3);
    if (byte_in == LEAD3_BYTE)      cls = BC_LEAD3;
    else if (byte_in == LEAD2_BYTE) cls = BC_LEAD2;
    else if (is_seg || is_asz)      cls = BC_PFX_OK;
    else if (is_bad)                cls = BC_PFX_BAD;
    else                            cls = BC_OTHER;
  end
endmodule

// File: rtl/vex_field_expand.sv
module vex_field_expand
  import vex_dec_pkg::*;
(
  input  logic              vex,
  input  logic              vex3,
  input  logic [BYTE_W-1:0] pay_a,
  input  logic [BYTE_W-1:0] pay_b,
  output vex_fields_t       f
);
  always_comb begin
    f = '0;
    if (vex) begin
      f.vsrc  = ~pay_b[6:3];
      f.vl256 = pay_b[2];
      f.pp    = pay_b[1:0];
      if (vex3) begin
        f.rext = ~pay_a[7];
        f.xext = ~pay_a[6];
        f.bext = ~pay_a[5];
        f.map  = pay_a[MAP_W-1:0];
        f.wide = pay_b[7];
      end else begin
        f.rext = ~pay_b[7];
        f.xext = 1'b0;
        f.bext = 1'b0;
        f.map  = MAP_ESC0F;
        f.wide = 1'b0;
      end
      case (f.pp)
        2'd0:    f.pfx_byte = 8'h00;
        2'd1:    f.pfx_byte = 8'h66;
        2'd2:    f.pfx_byte = 8'hF3;
        default: f.pfx_byte = 8'hF2;
      endcase
      f.map_bad = (f.map < MAP_ESC0F) || (f.map > MAP_LAST);
    end
  end
endmodule

// File: rtl/vex_modrm_split.sv
module vex_modrm_split
  import vex_dec_pkg::*;
(
  input  logic              present,
  input  logic [BYTE_W-1:0] mrm,
  input  logic              rext,
  input  logic              bext,
  output logic [1:0]        mod_f,
  output logic [2:0]        reg_f,
  output logic [2:0]        rm_f,
  output logic [IDX_W-1:0]  reg_idx,
  output logic [IDX_W-1:0]  rm_idx,
  output logic              sib
);
  always_comb begin
    mod_f   = present ? mrm[7:6] : 2'b00;
    reg_f   = present ? mrm[5:3] : 3'b000;
    rm_f    = present ? mrm[2:0] : 3'b000;
    reg_idx = present ? {rext, mrm[5:3]} : '0;
    rm_idx  = present ? {bext, mrm[2:0]} : '0;
    sib     = present && (mrm[2:0] == 3'b100) && (mrm[7:6] != 2'b11);
  end
endmodule

// File: rtl/vex_stream_decoder.sv
module vex_stream_decoder
  import vex_dec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              o_vex,
  output logic              o_vex3,
  output logic              o_illegal,
  output logic              o_map_bad,
  output logic              o_rext,
  output logic              o_xext,
  output logic              o_bext,
  output logic              o_wide,
  output logic [3:0]        o_vsrc,
  output logic              o_vl256,
  output logic [1:0]        o_pp,
  output logic [7:0]        o_pfx_byte,
  output logic [4:0]        o_map,
  output logic [7:0]        o_opcode,
  output logic              o_modrm_present,
  output logic [1:0]        o_mod,
  output logic [2:0]        o_reg,
  output logic [2:0]        o_rm,
  output logic [3:0]        o_reg_idx,
  output logic [3:0]        o_rm_idx,
  output logic              o_sib_follows
);
  dec_state_t        st;
  byte_cls_t         cls;
  vex_fields_t       fld;
  logic [BYTE_W-1:0] pay_a, pay_b, opc_q, mrm_q;
  logic              vex_q, vex3_q, bad_q, mrm_v_q;
  logic              accept;

  assign in_ready  = (st != ST_OUT);
  assign out_valid = (st == ST_OUT);
  assign accept    = in_valid && in_ready;

  vex_byte_class u_cls (.byte_in(in_data), .cls(cls));

  vex_field_expand u_exp (
    .vex(vex_q), .vex3(vex3_q), .pay_a(pay_a), .pay_b(pay_b), .f(fld)
  );

  vex_modrm_split u_mrm (
    .present(mrm_v_q), .mrm(mrm_q), .rext(fld.rext), .bext(fld.bext),
    .mod_f(o_mod), .reg_f(o_reg), .rm_f(o_rm),
    .reg_idx(o_reg_idx), .rm_idx(o_rm_idx), .sib(o_sib_follows)
  );

  always_ff @(posedge clk) begin
    if (rst || (st == ST_OUT && out_ready)) begin
      st      <= ST_PFX;
      pay_a   <= '0;
      pay_b   <= '0;
      opc_q   <= '0;
      mrm_q   <= '0;
      vex_q   <= 1'b0;
      vex3_q  <= 1'b0;
      bad_q   <= 1'b0;
      mrm_v_q <= 1'b0;
    end else if (accept) begin
      case (st)
        ST_PFX: begin
          case (cls)
            BC_PFX_OK:  ;
            BC_PFX_BAD: bad_q <= 1'b1;
            BC_LEAD3: begin
              vex_q  <= 1'b1;
              vex3_q <= 1'b1;
              st     <= ST_V3A;
            end
            BC_LEAD2: begin
              vex_q <= 1'b1;
              st    <= ST_V2A;
            end
            default: begin
              opc_q <= in_data;
              st    <= ST_OUT;
            end
          endcase
        end
        ST_V3A: begin
          pay_a <= in_data;
          st    <= ST_V3B;
        end
        ST_V3B, ST_V2A: begin
          pay_b <= in_data;
          st    <= ST_OPC;
        end
        ST_OPC: begin
          opc_q <= in_data;
          if (fld.map == MAP_ESC0F && in_data == NO_MRM_OPC) begin
            st <= ST_OUT;
          end else begin
            mrm_v_q <= 1'b1;
            st      <= ST_MRM;
          end
        end
        ST_MRM: begin
          mrm_q <= in_data;
          st    <= ST_OUT;
        end
        default: st <= ST_OUT;
      endcase
    end
  end

  assign o_vex           = vex_q;
  assign o_vex3          = vex3_q;
  assign o_illegal       = vex_q && bad_q;
  assign o_map_bad       = fld.map_bad;
  assign o_rext          = fld.rext;
  assign o_xext          = fld.xext;
  assign o_bext          = fld.bext;
  assign o_wide          = fld.wide;
  assign o_vsrc          = fld.vsrc;
  assign o_vl256         = fld.vl256;
  assign o_pp            = fld.pp;
  assign o_pfx_byte      = fld.pfx_byte;
  assign o_map           = fld.map;
  assign o_opcode        = opc_q;
  assign o_modrm_present = mrm_v_q;

  // R1: a held record does not change
  p_hold_stable_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid &&
      $stable({o_opcode, o_vsrc, o_map, o_illegal, o_reg_idx, o_rm_idx, o_pfx_byte}));

  // R1: handshake completes the record and reopens the input
  p_done_reopen_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |=> !out_valid && in_ready);

  // R3: plain instructions carry no map and no ModR/M
  p_plain_empty_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid && !o_vex |-> o_map == 5'd0 && !o_modrm_present && !o_illegal);

  // R5: compact form defaults
  p_short_dflt_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid && o_vex && !o_vex3 |-> o_map == 5'd1 && !o_wide && !o_xext && !o_bext);

  // R9: illegal flag only on VEX records
  p_illegal_vex_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && o_illegal |-> o_vex);

  // R10: VEX records carry ModR/M except map 1 opcode 77
  p_modrm_rule_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && o_vex && !(o_map == 5'd1 && o_opcode == 8'h77) |-> o_modrm_present);

  // R11: SIB only with a memory-form ModR/M
  p_sib_mem_r11: assert property (@(posedge clk) disable iff (rst)
    o_sib_follows |-> o_modrm_present && o_mod != 2'b11 && o_rm == 3'b100);
endmodule

// File: tb/vex_stream_decoder_test.sv
module vex_stream_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic out_ready = 1'b0;
  logic in_ready, out_valid;
  logic o_vex, o_vex3, o_illegal, o_map_bad, o_rext, o_xext, o_bext, o_wide;
  logic [3:0] o_vsrc;
  logic o_vl256;
  logic [1:0] o_pp;
  logic [7:0] o_pfx_byte;
  logic [4:0] o_map;
  logic [7:0] o_opcode;
  logic o_modrm_present;
  logic [1:0] o_mod;
  logic [2:0] o_reg, o_rm;
  logic [3:0] o_reg_idx, o_rm_idx;
  logic o_sib_follows;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  vex_stream_decoder uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .o_vex(o_vex), .o_vex3(o_vex3),
    .o_illegal(o_illegal), .o_map_bad(o_map_bad), .o_rext(o_rext), .o_xext(o_xext),
    .o_bext(o_bext), .o_wide(o_wide), .o_vsrc(o_vsrc), .o_vl256(o_vl256), .o_pp(o_pp),
    .o_pfx_byte(o_pfx_byte), .o_map(o_map), .o_opcode(o_opcode),
    .o_modrm_present(o_modrm_present), .o_mod(o_mod), .o_reg(o_reg), .o_rm(o_rm),
    .o_reg_idx(o_reg_idx), .o_rm_idx(o_rm_idx), .o_sib_follows(o_sib_follows)
  );

  function automatic logic [53:0] actual_vec();
    return {o_vex, o_vex3, o_illegal, o_map_bad, o_rext, o_xext, o_bext, o_wide,
            o_vsrc, o_vl256, o_pp, o_pfx_byte, o_map, o_opcode, o_modrm_present,
            o_mod, o_reg, o_rm, o_reg_idx, o_rm_idx, o_sib_follows};
  endfunction

  function automatic bit pfx_bad(input logic [7:0] b);
    return (b == 8'hF0) || (b == 8'h66) || (b == 8'hF2) || (b == 8'hF3) || (b >= 8'h40 && b <= 8'h4F);
  endfunction

  function automatic bit pfx_ok(input logic [7:0] b);
    return (b == 8'h67) || (b == 8'h26) || (b == 8'h2E) || (b == 8'h36) ||
           (b == 8'h3E) || (b == 8'h64) || (b == 8'h65);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at a negedge
  task automatic put(input logic [7:0] b);
    in_data  = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // form: 0 plain, 2 two-byte, 3 three-byte
  task automatic run(input int npre, input logic [7:0] p0, input logic [7:0] p1,
                     input int form, input logic [7:0] va, input logic [7:0] vb,
                     input logic [7:0] opc, input logic [7:0] mrm, input string req,
                     input bit hold);
    logic [53:0] exp, snap;
    bit bad, v3, r, x, bb, w, l, mb, hm, sb;
    logic [3:0] vs;
    logic [1:0] pp, md;
    logic [2:0] rg, rmv;
    logic [7:0] pb;
    logic [4:0] mp;
    bad = (npre > 0 && pfx_bad(p0)) || (npre > 1 && pfx_bad(p1));
    if (form == 0) begin
      exp = '0;
      exp[25:18] = opc;
    end else begin
      v3 = (form == 3);
      r  = v3 ? ~va[7] : ~vb[7];
      x  = v3 ? ~va[6] : 1'b0;
      bb = v3 ? ~va[5] : 1'b0;
      mp = v3 ? va[4:0] : 5'd1;
      w  = v3 ? vb[7] : 1'b0;
      vs = ~vb[6:3];
      l  = vb[2];
      pp = vb[1:0];
      pb = (pp == 0) ? 8'h00 : (pp == 1) ? 8'h66 : (pp == 2) ? 8'hF3 : 8'hF2;
      mb = !(mp >= 1 && mp <= 3);
      hm = !(mp == 5'd1 && opc == 8'h77);
      md = hm ? mrm[7:6] : 2'b0;
      rg = hm ? mrm[5:3] : 3'b0;
      rmv = hm ? mrm[2:0] : 3'b0;
      sb = hm && mrm[2:0] == 3'b100 && mrm[7:6] != 2'b11;
      exp = {1'b1, v3, bad, mb, r, x, bb, w, vs, l, pp, pb, mp, opc, hm, md, rg, rmv,
             hm ? {r, rg} : 4'h0, hm ? {bb, rmv} : 4'h0, sb};
    end
    if (npre > 0) put(p0);
    if (npre > 1) put(p1);
    if (form == 3) begin put(8'hC4); put(va); put(vb); end
    if (form == 2) begin put(8'hC5); put(vb); end
    put(opc);
    if (form != 0 && !(form == 2 && opc == 8'h77) && !(form == 3 && va[4:0] == 5'd1 && opc == 8'h77))
      put(mrm);
    while (!out_valid) @(negedge clk);
    check(actual_vec() == exp, req, {10'b0, actual_vec()}, {10'b0, exp});
    if (hold) begin
      snap = actual_vec();
      for (int k = 0; k < 4; k++) begin
        in_valid = 1'b1;
        in_data  = 8'hC4;
        @(negedge clk);
        check(out_valid && !in_ready && actual_vec() == snap, "R1 hold",
              {62'b0, out_valid, in_ready}, {62'b0, 2'b10});
      end
      in_valid = 1'b0;
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R1 release", {62'b0, out_valid, in_ready}, {62'b0, 2'b01});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2 reset state
    check(!out_valid && in_ready, "R2 reset", {62'b0, out_valid, in_ready}, {62'b0, 2'b01});

    // R3 every byte as first byte of a plain instruction
    for (int b = 0; b < 256; b++) begin
      if (b == 8'hC4 || b == 8'hC5) continue;
      if (pfx_ok(8'(b)) || pfx_bad(8'(b)))
        run(1, 8'(b), 8'h00, 0, 8'h00, 8'h00, 8'h90, 8'h00, "R3 prefix skip", 0);
      else
        run(0, 8'h00, 8'h00, 0, 8'h00, 8'h00, 8'(b), 8'h00, "R3 opcode pass", 0);
    end

    // R9 every prefix byte before a two-byte VEX
    for (int b = 0; b < 256; b++)
      if (pfx_ok(8'(b)) || pfx_bad(8'(b)))
        run(1, 8'(b), 8'h00, 2, 8'h00, 8'hF8, 8'h58, 8'hC1, "R9 prefix before VEX", 0);
    run(2, 8'h67, 8'h2E, 3, 8'hE1, 8'h7D, 8'h10, 8'h04, "R9 allowed pair", 0);
    run(2, 8'h2E, 8'hF0, 3, 8'hE1, 8'h7D, 8'h10, 8'h04, "R9 lock then VEX", 0);

    // R4 R8 three-byte first payload sweep
    for (int b = 0; b < 256; b++)
      run(0, 8'h00, 8'h00, 3, 8'(b), 8'h7D, 8'h10, 8'h04, "R4 R8 map/ext sweep", 0);
    // R4 R6 R7 three-byte second payload sweep
    for (int b = 0; b < 256; b++)
      run(0, 8'h00, 8'h00, 3, 8'hE2, 8'(b), 8'h18, 8'hC0, "R4 R6 R7 width/src sweep", 0);
    // R5 two-byte payload sweep
    for (int b = 0; b < 256; b++)
      run(0, 8'h00, 8'h00, 2, 8'h00, 8'(b), 8'h58, 8'h3C, "R5 short form sweep", 0);
    // R10 R11 ModR/M sweep with extensions set
    for (int b = 0; b < 256; b++)
      run(0, 8'h00, 8'h00, 3, 8'h02, 8'h45, 8'h40, 8'(b), "R10 R11 modrm sweep", 0);

    // R10 opcode 77 rule
    run(0, 8'h00, 8'h00, 2, 8'h00, 8'hF8, 8'h77, 8'h00, "R10 short 77", 0);
    run(0, 8'h00, 8'h00, 3, 8'hE1, 8'h7C, 8'h77, 8'h00, "R10 map1 77", 0);
    run(0, 8'h00, 8'h00, 3, 8'hE2, 8'h7C, 8'h77, 8'h84, "R10 map2 77", 0);

    // R1 back-pressure with bytes offered during hold
    run(0, 8'h00, 8'h00, 3, 8'h62, 8'hB5, 8'h5A, 8'h24, "R1 held record", 1);
    run(0, 8'h00, 8'h00, 0, 8'h00, 8'h00, 8'h90, 8'h00, "R1 after hold", 0);

    // R2 reset mid prefix
    put(8'hC4);
    put(8'hE1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!out_valid && in_ready, "R2 mid reset", {62'b0, out_valid, in_ready}, {62'b0, 2'b01});
    run(0, 8'h00, 8'h00, 0, 8'h00, 8'h00, 8'hC3, 8'h00, "R2 after reset", 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule